// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block is a short queue of prefetched cache lines that sits next to a first-level cache. The cache presents every lookup to the block at the same time as it probes its own arrays, together with a flag saying whether the cache itself hit. Lines that the block has prefetched stay in its own queue and never go into the cache on speculation. A line enters the cache only when a demand lookup matches the oldest entry of the queue. In that cycle the block hands the line over on its fill output and frees the slot.

A lookup that misses both the cache and the buffer discards the whole queue and starts a new stream. The block then requests, one per accepted handshake, the lines that follow the missing line. Each slot freed by a head hit makes room for exactly one more request, which continues the stream from the last line requested. Memory returns data in request order. Each response completes the oldest entry still waiting for data. Responses that belong to requests made before a restart are dropped.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset no memory request is made and no lookup is reported as a buffer hit until the first lookup that misses both the cache and the buffer.
- R2: A lookup with `lkValid` high, `lkCacheHit` low and no buffer hit restarts the stream. The next DEPTH accepted requests carry line numbers L+1, L+2, … L+DEPTH in that order, where L is the line number (`lkAddr` shifted right by log2(LINE_BYTES)). Line numbers wrap modulo 2^(ADDR_W−log2(LINE_BYTES)), and `memReqAddr` has all offset bits zero.
- R3: When a lookup matches the head entry, `lkBufHit` and `fillValid` are high in that same cycle. `fillAddr` is then the line-aligned address of the head line and `fillData` is the response data returned for that line.
- R4: Each head hit causes exactly one further request, for the line after the last line requested.
- R5: Only the head entry is compared. A lookup whose line is held further back in the queue is handled as a miss and restarts the stream at that line plus one.
- R6: An entry still waiting for its response cannot supply data. A lookup to such a head line is a miss.
- R7: A lookup with `lkCacheHit` high has no effect. There is no buffer hit, no fill and no change to the requests or the queue contents.
- R8: Responses fill entries in request order. Responses to requests made before a restart are discarded and never reach `fillData`.
- R9: At most 2·DEPTH requests are outstanding at memory, and a new entry is only written into a free slot.
- R10: A request that is not accepted stays asserted until accepted. Its address holds until then, except across a stream restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | A lookup is presented this cycle |
| lkAddr | input | ADDR_W | Byte address of the lookup |
| lkCacheHit | input | 1 | The cache itself hit on this lookup |
| lkBufHit | output | 1 | The head entry supplies this lookup |
| fillValid | output | 1 | Line handed to the cache this cycle |
| fillAddr | output | ADDR_W | Line-aligned address of the handed-over line |
| fillData | output | DATA_W | Data of the handed-over line |
| memReqValid | output | 1 | Line request to memory |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Line-aligned request address |
| memRespValid | input | 1 | Response data returned, in request order |
| memRespData | input | DATA_W | Returned line data |

## Verification
The bench builds the block with DEPTH 4, 16-byte lines and a 12-bit address, so line numbers are only 8 bits wide. A sweep of stream start points can therefore run past line 255 and check the wrap to line 0. The shallow queue lets a few consumed lines cover the full cycle of refills. It also lets a held-off memory reach the 2·DEPTH outstanding limit with only a handful of restarts. A fixed five-cycle memory latency keeps freshly requested heads pending long enough to probe the pending-entry and stale-response cases. A stalling-ready mode exercises the request hold rule.

// File: rtl/spb_pkg.sv
package spb_pkg;
  // Strobes from the control unit to the entry storage
  typedef struct packed {
    logic flush;  // discard every entry
    logic alloc;  // write a new pending entry at the tail
    logic pop;    // free the head entry
    logic fill;   // complete the oldest pending entry
  } spb_strobe_t;
endpackage

// File: rtl/spb_dpath.sv
module spb_dpath
  import spb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spb_strobe_t       ctl,
  input  logic [IDX_W-1:0]  headIdx,
  input  logic [IDX_W-1:0]  tailIdx,
  input  logic [IDX_W-1:0]  fillIdx,
  input  logic [LINE_W-1:0] allocLine,
  input  logic [DATA_W-1:0] respData,
  input  logic [LINE_W-1:0] lkLine,
  output logic              headHit,
  output logic [LINE_W-1:0] headLine,
  output logic [DATA_W-1:0] headData
);
  logic [DEPTH-1:0]  validQ;
  logic [DEPTH-1:0]  pendQ;
  logic [LINE_W-1:0] lineQ [DEPTH];
  logic [DATA_W-1:0] dataQ [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        pendQ[g]  <= 1'b0;
      end else if (ctl.flush) begin
        validQ[g] <= 1'b0;
        pendQ[g]  <= 1'b0;
      end else begin
        if (ctl.alloc && tailIdx == MY_IDX) begin
          validQ[g] <= 1'b1;
          pendQ[g]  <= 1'b1;
        end else if (ctl.pop && headIdx == MY_IDX) begin
          validQ[g] <= 1'b0;
        end
        if (ctl.fill && fillIdx == MY_IDX) pendQ[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (ctl.alloc && tailIdx == MY_IDX) lineQ[g] <= allocLine;
      if (ctl.fill && fillIdx == MY_IDX)  dataQ[g] <= respData;
    end
  end

  assign headLine = lineQ[headIdx];
  assign headData = dataQ[headIdx];
  assign headHit  = validQ[headIdx] && !pendQ[headIdx] && (lineQ[headIdx] == lkLine);

  // R8: a response always lands on a live entry still waiting for data
  assert_fill_pend_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |-> (validQ[fillIdx] && pendQ[fillIdx]));
  // R9: a new entry only overwrites a free slot
  assert_alloc_free_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.alloc |-> !validQ[tailIdx]);
  // R2: after a restart the head is empty or still waiting on memory
  assert_flush_head_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (!validQ[headIdx] || pendQ[headIdx]));
endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl
  import spb_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic              lkCacheHit,
  input  logic [LINE_W-1:0] lkLine,
  input  logic              headHit,
  input  logic              memReqReady,
  input  logic              memRespValid,
  output spb_strobe_t       ctl,
  output logic [IDX_W-1:0]  headIdx,
  output logic [IDX_W-1:0]  tailIdx,
  output logic [IDX_W-1:0]  fillIdx,
  output logic [LINE_W-1:0] reqLine,
  output logic              memReqValid,
  output logic              bufHit
);
  localparam int OUT_MAX = 2 * DEPTH;

  logic [IDX_W-1:0]  headQ, tailQ, fillQ;
  logic [CNT_W-1:0]  countQ, outCnt, staleCnt;
  logic [LINE_W-1:0] reqLineQ;
  logic              activeQ;
  logic              probe, miss, issue;

  function automatic logic [IDX_W-1:0] incIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    probe       = lkValid && !lkCacheHit;
    bufHit      = probe && headHit;
    miss        = probe && !headHit;
    memReqValid = activeQ && (countQ < CNT_W'(DEPTH)) && (outCnt < CNT_W'(OUT_MAX));
    issue       = memReqValid && memReqReady;
    ctl.flush   = miss;
    ctl.pop     = bufHit;
    ctl.alloc   = issue && !miss;
    ctl.fill    = memRespValid && (staleCnt == '0) && !miss;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headQ    <= '0;
      tailQ    <= '0;
      fillQ    <= '0;
      countQ   <= '0;
      outCnt   <= '0;
      staleCnt <= '0;
      reqLineQ <= '0;
      activeQ  <= 1'b0;
    end else begin
      outCnt <= outCnt + CNT_W'(issue) - CNT_W'(memRespValid);
      if (miss) begin
        headQ    <= '0;
        tailQ    <= '0;
        fillQ    <= '0;
        countQ   <= '0;
        reqLineQ <= lkLine + 1'b1;
        activeQ  <= 1'b1;
        staleCnt <= outCnt + CNT_W'(issue) - CNT_W'(memRespValid);
      end else begin
        if (ctl.pop)   headQ <= incIdx(headQ);
        if (ctl.alloc) begin
          tailQ    <= incIdx(tailQ);
          reqLineQ <= reqLineQ + 1'b1;
        end
        if (ctl.fill)  fillQ <= incIdx(fillQ);
        countQ <= countQ + CNT_W'(ctl.alloc) - CNT_W'(ctl.pop);
        if (memRespValid && staleCnt != '0) staleCnt <= staleCnt - 1'b1;
      end
    end
  end

  assign headIdx = headQ;
  assign tailIdx = tailQ;
  assign fillIdx = fillQ;
  assign reqLine = reqLineQ;

  // R10: an unaccepted request is held
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);
  // R10: its address holds unless a restart intervenes
  assert_req_addr_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !miss) |=> $stable(reqLine));
  // R8: memory never answers more than was asked
  assert_resp_owed_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRespValid |-> (outCnt != '0));
endmodule

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf
  import spb_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkCacheHit,
  output logic              lkBufHit,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] fillData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRespValid,
  input  logic [DATA_W-1:0] memRespData
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(2 * DEPTH + 1);

  spb_strobe_t       ctl;
  logic [IDX_W-1:0]  headIdx, tailIdx, fillIdx;
  logic [LINE_W-1:0] lkLine, reqLine, headLine;
  logic              headHit, bufHit;
  logic              unusedOffset;

  assign lkLine       = lkAddr[ADDR_W-1:OFF_W];
  assign unusedOffset = ^lkAddr[OFF_W-1:0];

  spb_ctrl #(.DEPTH(DEPTH), .LINE_W(LINE_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkCacheHit(lkCacheHit),
    .lkLine(lkLine), .headHit(headHit), .memReqReady(memReqReady),
    .memRespValid(memRespValid), .ctl(ctl), .headIdx(headIdx), .tailIdx(tailIdx),
    .fillIdx(fillIdx), .reqLine(reqLine), .memReqValid(memReqValid), .bufHit(bufHit)
  );

  spb_dpath #(.DEPTH(DEPTH), .LINE_W(LINE_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .headIdx(headIdx), .tailIdx(tailIdx),
    .fillIdx(fillIdx), .allocLine(reqLine), .respData(memRespData), .lkLine(lkLine),
    .headHit(headHit), .headLine(headLine), .headData(fillData)
  );

  assign lkBufHit   = bufHit;
  assign fillValid  = bufHit;
  assign fillAddr   = {headLine, {OFF_W{1'b0}}};
  assign memReqAddr = {reqLine, {OFF_W{1'b0}}};
endmodule

// File: tb/tb_stream_prefetch_buf.sv
module tb_stream_prefetch_buf;
  localparam int DEPTH = 4;
  localparam int LAT   = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkCacheHit = 1'b0;
  logic [11:0] lkAddr = '0;
  logic        lkBufHit, fillValid, memReqValid;
  logic [11:0] fillAddr, memReqAddr;
  logic [15:0] fillData;
  logic        memReqReady = 1'b1;
  logic        memRespValid = 1'b0;
  logic [15:0] memRespData = '0;

  int nVec = 0, nErr = 0;
  logic [11:0] reqLog [0:1023];
  int dueAt [0:1023];
  int nReq = 0, nResp = 0, cyc = 0, pc = 0, maxOut = 0;
  bit stall = 0, hold = 0;

  always #5 clk = ~clk;

  stream_prefetch_buf #(.DEPTH(DEPTH), .LINE_BYTES(16), .ADDR_W(12), .DATA_W(16)) dut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAddr(lkAddr), .lkCacheHit(lkCacheHit),
    .lkBufHit(lkBufHit), .fillValid(fillValid), .fillAddr(fillAddr), .fillData(fillData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  function automatic logic [15:0] dataOf(input logic [11:0] a);
    return {4'h0, a} * 16'd5 + 16'h03C1;
  endfunction

  function automatic logic [11:0] lineAddr(input int ln);
    return {ln[7:0], 4'h0};
  endfunction

  // memory model: samples at the falling edge, answers in order after LAT
  always @(negedge clk) begin
    if (rstN && memReqValid && memReqReady) begin
      reqLog[nReq] = memReqAddr;
      dueAt[nReq]  = cyc + LAT;
      nReq++;
      if (nReq - nResp > maxOut) maxOut = nReq - nResp;
    end
    memRespValid = 1'b0;
    if (!hold && nResp < nReq && dueAt[nResp] <= cyc) begin
      memRespValid = 1'b1;
      memRespData  = dataOf(reqLog[nResp]);
      nResp++;
    end
    cyc++;
  end

  always @(posedge clk) begin
    #2;
    memReqReady = !stall || (pc % 3 != 1);
    pc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic lookup(input logic [11:0] a, input logic ch, output logic hit,
                        output logic fv, output logic [15:0] fd, output logic [11:0] fa);
    @(posedge clk); #2;
    lkValid = 1'b1; lkAddr = a; lkCacheHit = ch;
    @(negedge clk);
    hit = lkBufHit; fv = fillValid; fd = fillData; fa = fillAddr;
    @(posedge clk); #2;
    lkValid = 1'b0; lkCacheHit = 1'b0;
  endtask

  task automatic expectHit(input int ln, input string req);
    logic h, fv; logic [15:0] fd; logic [11:0] fa;
    lookup(lineAddr(ln) | 12'h7, 1'b0, h, fv, fd, fa);
    chk(h && fv, req, {h, fv}, 2'b11);
    chk(fd == dataOf(lineAddr(ln)), req, fd, dataOf(lineAddr(ln)));
    chk(fa == lineAddr(ln), req, fa, lineAddr(ln));
  endtask

  initial begin
    #1_500_000;
    nVec++; nErr++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end

  initial begin
    logic h, fv; logic [15:0] fd; logic [11:0] fa;
    int base, s;
    int starts [4] = '{16'h10, 16'h7E, 16'hFD, 16'hFF};
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: idle after reset, and a cache-hit lookup does not start anything
    idle(10);
    @(negedge clk);
    chk(!memReqValid, "R1", memReqValid, 0);
    lookup(12'h345, 1'b1, h, fv, fd, fa);
    chk(!h, "R1", h, 0);
    idle(20);
    chk(nReq == 0, "R1 R7", nReq, 0);

    // R2 R3 R4: sweep of stream starts, including line wrap, with and without stalls
    for (int m = 0; m < 2; m++) begin
      stall = (m == 1);
      for (int si = 0; si < 4; si++) begin
        s = starts[si];
        base = nReq;
        lookup(lineAddr(s) | 12'h9, 1'b0, h, fv, fd, fa);
        chk(!h && !fv, "R2", h, 0);
        idle(40);
        chk(nReq - base == DEPTH, "R2", nReq - base, DEPTH);
        for (int k = 0; k < DEPTH; k++)
          chk(reqLog[base + k] == lineAddr(s + 1 + k), "R2", reqLog[base + k], lineAddr(s + 1 + k));
        for (int j = 0; j < 6; j++) begin
          expectHit(s + 1 + j, "R3");
          idle(40);
          chk(nReq - base == DEPTH + 1 + j, "R4", nReq - base, DEPTH + 1 + j);
          chk(reqLog[nReq - 1] == lineAddr(s + DEPTH + 1 + j), "R4",
              reqLog[nReq - 1], lineAddr(s + DEPTH + 1 + j));
        end
      end
    end
    stall = 0;

    // R5: queue now holds lines 06..09; a match on 08 is not the head
    base = nReq;
    lookup(lineAddr(8), 1'b0, h, fv, fd, fa);
    chk(!h, "R5", h, 0);
    idle(40);
    chk(nReq - base == DEPTH, "R5", nReq - base, DEPTH);
    chk(reqLog[base] == lineAddr(9), "R5", reqLog[base], lineAddr(9));
    expectHit(9, "R5");
    idle(40);

    // R7: head is line 0A; a cache hit on it changes nothing
    base = nReq;
    lookup(lineAddr(10), 1'b1, h, fv, fd, fa);
    chk(!h && !fv, "R7", {h, fv}, 0);
    idle(40);
    chk(nReq == base, "R7", nReq - base, 0);
    expectHit(10, "R7");
    idle(40);

    // R6 R8: head still pending -> miss; stale responses must not leak
    lookup(lineAddr(16'h40), 1'b0, h, fv, fd, fa);
    lookup(lineAddr(16'h41), 1'b0, h, fv, fd, fa);
    chk(!h, "R6", h, 0);
    idle(40);
    for (int k = 0; k < DEPTH; k++)
      chk(reqLog[nReq - DEPTH + k] == lineAddr(16'h42 + k), "R8",
          reqLog[nReq - DEPTH + k], lineAddr(16'h42 + k));
    expectHit(16'h42, "R8");
    expectHit(16'h43, "R8");
    idle(40);

    // R9: memory held off, repeated restarts must stop at 2*DEPTH outstanding
    hold = 1; maxOut = nReq - nResp;
    for (int r = 0; r < 5; r++) begin
      lookup(lineAddr(16'h60 + 16 * r), 1'b0, h, fv, fd, fa);
      idle(10);
    end
    chk(maxOut == 2 * DEPTH, "R9", maxOut, 2 * DEPTH);
    hold = 0;
    idle(100);
    expectHit(16'hA1, "R8 R9");
    expectHit(16'hA2, "R8 R9");
    idle(5);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nErr);
    $finish;
  end
endmodule